// File: doc/BRIEF.md
# Pipelined Full-Width Unsigned Multiplier with Residue-Derived High Word

This block multiplies two W-bit unsigned operands and returns the whole 2W-bit product as a low word and a high word. The double-width product is never formed. The datapath builds two W-column products instead. The first is the ordinary product modulo 2^W, which is the low word. The second is the product modulo 2^W-1. For the second product every partial-product bit that would fall at column W or above is folded back to column (position - W), which gives a square array of W rows by W columns. The high word is then recovered as (x - L) mod (2^W-1). Here x is the folded product and L is the low word. The recovered value is the exact high half, because the high half of any W-by-W product is at most 2^W-2.

Both products go through carry-save trees. Each tree reduces its W rows to three. A final carry-propagate stage then finishes each sum. The folded path uses end-around carries, and an all-ones result there stands for zero. The pipeline has three register stages: operand capture, the three-row carry-save result, and the final words. A new operand pair can be issued on every clock, and a valid flag travels alongside the data.

Top module: `mh_mul_hilo`

## Requirements
- R1: `o_valid` equals the `i_valid` value sampled three rising edges earlier. Data sampled at edge n appears on the outputs right after edge n+2. During reset `o_valid` is 0.
- R2: Operand pairs offered with `i_valid`=1 on consecutive cycles each produce their own result on consecutive cycles, with no stall and no lost pair.
- R3: `o_lo` equals (a*b) mod 2^W for the pair captured three edges earlier.
- R4: `o_hi` equals floor(a*b / 2^W), the upper W bits of the exact 2W-bit product.
- R5: `o_hi` is never all ones when `o_valid`=1.
- R6: If either operand is 0, both `o_lo` and `o_hi` are 0.
- R7: If `i_b` is 1, `o_lo` equals `i_a` and `o_hi` is 0 (three edges later).
- R8: With both operands all ones, `o_lo` is 1 and `o_hi` is 2^W-2.
- R9: After a synchronous active-high reset, `o_valid`, `o_lo` and `o_hi` read 0 until valid data arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Operand pair on `i_a`/`i_b` is valid |
| i_a | input | W | Multiplicand, unsigned |
| i_b | input | W | Multiplier, unsigned |
| o_valid | output | 1 | Result words are valid |
| o_lo | output | W | Low word of the product |
| o_hi | output | W | High word of the product |

## Verification
On every cycle the assertions check four things: the three-cycle valid latency, that the low word matches the truncated product of the operands seen three edges earlier, that the high word never reads all ones, and the results for zero and unit operands. Only the bench can show that the high word is the exact upper half of the product. It does this by comparing both words with a full double-width reference. The bench cases include all-ones operands, powers of two, sparse and random values, and back-to-back issue with bubbles between pairs.

// File: rtl/mh_pkg.sv
package mh_pkg;
    parameter int unsigned MH_DEF_W = 64;
    localparam int unsigned MH_LAT  = 3;

    // Number of 3:2 compressor levels needed to bring n rows down to 3.
    function automatic int mh_levels(input int n);
        int k;
        int r;
        k = 0;
        r = n;
        while (r > 3) begin
            r = (r / 3) * 2 + (r % 3);
            k++;
        end
        return k;
    endfunction
endpackage

// File: rtl/mh_pp_tree.sv
module mh_pp_tree
    import mh_pkg::*;
#(
    parameter int unsigned W    = MH_DEF_W,
    parameter bit          WRAP = 1'b0
) (
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    output logic [2:0][W-1:0]   rows
);
    localparam int LVL = mh_levels(W);
    localparam int GRP = W / 3;

    logic [W-1:0] pp [W];

    // Partial products: shifted (truncating) or rotated (folding) copies.
    for (genvar i = 0; i < W; i++) begin : g_pp
        if (WRAP) begin : g_rot
            if (i == 0) begin : g_z
                assign pp[i] = b[i] ? a : '0;
            end else begin : g_nz
                assign pp[i] = b[i] ? ((a << i) | (a >> (W - i))) : '0;
            end
        end else begin : g_shf
            assign pp[i] = b[i] ? (a << i) : '0;
        end
    end

    // Level-by-level carry-save reduction down to three rows.
    always_comb begin
        logic [W-1:0] cur [W];
        logic [W-1:0] nxt [W];
        logic [W-1:0] x0, x1, x2, mj;
        int n;
        int m;
        int full;
        for (int k = 0; k < W; k++) cur[k] = pp[k];
        n = W;
        for (int s = 0; s < LVL; s++) begin
            for (int k = 0; k < W; k++) nxt[k] = '0;
            m = 0;
            for (int g = 0; g < GRP; g++) begin
                if (3 * g + 2 < n) begin
                    x0 = cur[3*g];
                    x1 = cur[3*g+1];
                    x2 = cur[3*g+2];
                    mj = (x0 & x1) | (x0 & x2) | (x1 & x2);
                    nxt[m] = x0 ^ x1 ^ x2;
                    if (WRAP) nxt[m+1] = {mj[W-2:0], mj[W-1]};
                    else      nxt[m+1] = {mj[W-2:0], 1'b0};
                    m = m + 2;
                end
            end
            full = (n / 3) * 3;
            for (int k = 0; k < 2; k++) begin
                if (full + k < n) begin
                    nxt[m] = cur[full+k];
                    m = m + 1;
                end
            end
            n = m;
            for (int k = 0; k < W; k++) cur[k] = nxt[k];
        end
        rows[0] = cur[0];
        rows[1] = cur[1];
        rows[2] = cur[2];
    end
endmodule

// File: rtl/mh_final.sv
module mh_final
    import mh_pkg::*;
#(
    parameter int unsigned W = MH_DEF_W
) (
    input  logic [2:0][W-1:0] lo_rows,
    input  logic [2:0][W-1:0] wr_rows,
    output logic [W-1:0]      lo,
    output logic [W-1:0]      hi
);
    // Addition modulo 2^W-1 with end-around carry; all ones maps to 0.
    function automatic logic [W-1:0] eac_add(input logic [W-1:0] p, input logic [W-1:0] q);
        logic [W:0]   t;
        logic [W-1:0] s;
        t = {1'b0, p} + {1'b0, q};
        s = t[W-1:0] + {{(W-1){1'b0}}, t[W]};
        return (&s) ? '0 : s;
    endfunction

    logic [W-1:0] ws, wm, wc, xres;

    always_comb begin
        ws   = wr_rows[0] ^ wr_rows[1] ^ wr_rows[2];
        wm   = (wr_rows[0] & wr_rows[1]) | (wr_rows[0] & wr_rows[2]) | (wr_rows[1] & wr_rows[2]);
        wc   = {wm[W-2:0], wm[W-1]};
        xres = eac_add(ws, wc);
        lo   = lo_rows[0] + lo_rows[1] + lo_rows[2];
        hi   = eac_add(xres, ~lo);
    end
endmodule

// File: rtl/mh_mul_hilo.sv
module mh_mul_hilo
    import mh_pkg::*;
#(
    parameter int unsigned W = MH_DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_valid,
    input  logic [W-1:0] i_a,
    input  logic [W-1:0] i_b,
    output logic         o_valid,
    output logic [W-1:0] o_lo,
    output logic [W-1:0] o_hi
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } opnd_t;

    typedef struct packed {
        logic               vld;
        logic [2:0][W-1:0]  lo_rows;
        logic [2:0][W-1:0]  wr_rows;
    } rows_t;

    opnd_t             s1;
    rows_t             s2;
    logic [2:0][W-1:0] lo_rows_c, wr_rows_c;
    logic [W-1:0]      lo_c, hi_c;

    // Stage 1: operand capture
    always_ff @(posedge clk) begin
        if (rst) s1 <= '0;
        else     s1 <= '{vld: i_valid, a: i_a, b: i_b};
    end

    mh_pp_tree #(.W(W), .WRAP(1'b0)) u_lo_tree (.a(s1.a), .b(s1.b), .rows(lo_rows_c));
    mh_pp_tree #(.W(W), .WRAP(1'b1)) u_wr_tree (.a(s1.a), .b(s1.b), .rows(wr_rows_c));

    // Stage 2: three-row carry-save results of both trees
    always_ff @(posedge clk) begin
        if (rst) s2 <= '0;
        else     s2 <= '{vld: s1.vld, lo_rows: lo_rows_c, wr_rows: wr_rows_c};
    end

    mh_final #(.W(W)) u_final (
        .lo_rows (s2.lo_rows),
        .wr_rows (s2.wr_rows),
        .lo      (lo_c),
        .hi      (hi_c)
    );

    // Stage 3: output words
    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_lo    <= '0;
            o_hi    <= '0;
        end else begin
            o_valid <= s2.vld;
            o_lo    <= lo_c;
            o_hi    <= hi_c;
        end
    end

    // Edges since reset, saturating, so that $past windows stay after reset.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (o_valid == $past(i_valid, 3)));   // R1
    AST_LO_TRUNC: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && o_valid) |-> (o_lo == $past(i_a * i_b, 3)));   // R3
    AST_HI_NOT_ONES: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> !(&o_hi));   // R5
    AST_ZERO_OPND: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(i_valid && (i_a == '0 || i_b == '0), 3)) |-> (o_lo == '0 && o_hi == '0));   // R6
    AST_UNIT_OPND: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(i_valid && i_b == W'(1), 3)) |-> (o_lo == $past(i_a, 3) && o_hi == '0));   // R7
endmodule

// File: tb/sim_mh_mul_hilo.sv
module sim_mh_mul_hilo;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         i_valid;
    logic [W-1:0] i_a, i_b;
    logic         o_valid;
    logic [W-1:0] o_lo, o_hi;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    mh_mul_hilo #(.W(W)) u0 (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_a(i_a), .i_b(i_b),
        .o_valid(o_valid), .o_lo(o_lo), .o_hi(o_hi)
    );

    // Bench-side delay line of what was offered (three edges deep).
    logic         ev [3];
    logic [W-1:0] ea [3];
    logic [W-1:0] eb [3];

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                ev[k] <= 1'b0; ea[k] <= '0; eb[k] <= '0;
            end
        end else begin
            ev[0] <= i_valid; ea[0] <= i_a; eb[0] <= i_b;
            for (int k = 1; k < 3; k++) begin
                ev[k] <= ev[k-1]; ea[k] <= ea[k-1]; eb[k] <= eb[k-1];
            end
        end
    end

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
        return {{W{1'b0}}, a} * {{W{1'b0}}, b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    bit prev_v = 1'b0;

    // Check the output of the pair offered three edges back, then drive a new one.
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p;
        @(negedge clk);
        chk(o_valid == ev[2], (prev_v && ev[2]) ? "R2 valid back-to-back" : "R1 valid latency",
            W'(o_valid), W'(ev[2]));
        if (ev[2]) begin
            p = ref_prod(ea[2], eb[2]);
            chk(o_lo == p[W-1:0], "R3 low word", o_lo, p[W-1:0]);
            chk(o_hi == p[2*W-1:W], "R4 high word", o_hi, p[2*W-1:W]);
            chk(!(&o_hi), "R5 high not all ones", o_hi, '0);
            if (ea[2] == '0 || eb[2] == '0)
                chk(o_lo == '0 && o_hi == '0, "R6 zero operand", o_lo | o_hi, '0);
            if (eb[2] == W'(1))
                chk(o_lo == ea[2] && o_hi == '0, "R7 unit operand", o_lo, ea[2]);
            if (&ea[2] && &eb[2]) begin
                chk(o_lo == W'(1), "R8 max low", o_lo, W'(1));
                chk(o_hi == {{(W-1){1'b1}}, 1'b0}, "R8 max high", o_hi, {{(W-1){1'b1}}, 1'b0});
            end
        end
        prev_v  = ev[2];
        i_valid = v;
        i_a     = a;
        i_b     = b;
    endtask

    function automatic logic [W-1:0] rnd_word(input int mode);
        logic [W-1:0] r;
        r = {$urandom, $urandom};
        case (mode)
            0: return r;
            1: return W'(1) << ($urandom % W);
            2: return '1;
            3: return W'($urandom % 8);
            4: return r & {$urandom, $urandom} & {$urandom, $urandom};
            default: return ~(W'(1) << ($urandom % W));
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; i_valid = 1'b0; i_a = '0; i_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(o_valid == 1'b0, "R9 reset valid", W'(o_valid), '0);
        chk(o_lo == '0, "R9 reset low", o_lo, '0);
        chk(o_hi == '0, "R9 reset high", o_hi, '0);

        // Directed corners, issued back to back (R2)
        step(1'b1, '0, '1);
        step(1'b1, '1, '0);
        step(1'b1, 64'h1234_5678_9abc_def0, W'(1));
        step(1'b1, W'(1), 64'hfedc_ba98_7654_3210);
        step(1'b1, '1, '1);
        step(1'b1, '1, W'(1));
        step(1'b1, '1, W'(2));
        step(1'b1, W'(1) << (W-1), W'(1) << (W-1));
        step(1'b1, W'(1) << 32, W'(1) << 31);
        step(1'b1, 64'h8000_0000_0000_0001, '1);
        step(1'b1, {1'b0, {(W-1){1'b1}}}, {1'b0, {(W-1){1'b1}}});
        step(1'b0, '1, '1);
        step(1'b1, 64'hffff_ffff_0000_0000, 64'h0000_0000_ffff_ffff);

        // Constrained random with bubbles
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 5) != 0, rnd_word($urandom % 6), rnd_word($urandom % 6));
        end
        for (int n = 0; n < 4; n++) step(1'b0, '0, '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule